// File: doc/BRIEF.md
# Packed Horizontal Add-Subtract Unit

This block is a floating-point vector datapath. It takes two 128-bit operands, A and B, and returns one 128-bit result. In single-precision mode each operand is split into four 32-bit lanes. In double-precision mode it is split into two 64-bit lanes. A two-bit opcode chooses how operand lanes are paired before they reach the per-lane adders:

- **Alternating mode** works lane-to-lane. Even result lanes subtract and odd result lanes add.
- **Horizontal modes** pair neighbouring elements inside one operand. The low half of the result comes from A and the high half from B.
- **Pass-through** (opcode 11) returns A unchanged.

Every lane adder rounds to nearest-even. It flushes subnormal inputs and results to zero and returns a canonical quiet NaN for invalid operations.

An upstream issue stage offers an operation with a valid/ready handshake. The result is held in a single output register until the consumer takes it. A new operation can be accepted in every cycle in which the output register is empty or being drained.

Top module: `hsa_unit`

## Requirements
- R1: With opcode 00 in single mode, result lane i (bits 32i+31:32i) equals A_i − B_i for i = 0 and 2, and A_i + B_i for i = 1 and 3.
- R2: With opcode 01 in single mode, result lanes 0..3 are A0+A1, A2+A3, B0+B1, B2+B3.
- R3: With opcode 10 in single mode, result lanes 0..3 are A0−A1, A2−A3, B0−B1, B2−B3. The higher-indexed element is always the subtrahend.
- R4: With the precision bit set, the operands are taken as two 64-bit double lanes (lane 0 = bits 63:0). Opcode 00 gives A0−B0 and A1+B1. Opcode 01 gives A0+A1 and B0+B1. Opcode 10 gives A0−A1 and B0−B1.
- R5: Opcode 11 returns operand A bit-for-bit in either precision, including NaN and subnormal encodings.
- R6: Every lane sum is rounded to nearest with ties going to the even significand.
- R7: A zero exponent field with a nonzero fraction is treated as zero on input. A result whose magnitude falls below the smallest normal is returned as zero with the sign of the larger operand.
- R8: A finite result that exceeds the largest normal returns infinity with the result's sign.
- R9: A NaN input, or the sum of infinities with opposite effective signs, gives the quiet NaN 0x7FC00000 in single mode or 0x7FF8000000000000 in double mode.
- R10: The result and its valid flag appear on the clock edge that accepts the operation. Back-to-back operations are accepted on consecutive edges while the output is ready.
- R11: While the output is valid and not ready, the input ready is low and the output data and valid hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_op | input | 2 | 00 alternate, 01 horizontal add, 10 horizontal subtract, 11 pass A |
| in_dbl | input | 1 | 1 selects two 64-bit lanes, 0 selects four 32-bit lanes |
| in_a | input | VEC_W | Operand A |
| in_b | input | VEC_W | Operand B |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | VEC_W | Result vector |

## Verification
All of the block's state sits in one output register. A wrong valid bit or a wrong hold condition therefore shows up on the very next edge, as a lost, duplicated or changed result during backpressure. A wrong lane pairing or sign choice shows up in the same cycle as a wrong value in one specific output lane. Sweeps over every opcode in both precisions with exactly representable operands pin down the steering. Directed ties, overflows, subnormals and NaN/infinity mixes cover the rounding and special-value paths, which a mistake in normalization would corrupt only at those edges.

// File: rtl/hsa_pkg.sv
package hsa_pkg;

    localparam int SP_EW = 8;
    localparam int SP_MW = 23;
    localparam int SP_W  = SP_EW + SP_MW + 1;
    localparam int DP_EW = 11;
    localparam int DP_MW = 52;
    localparam int DP_W  = DP_EW + DP_MW + 1;

    typedef enum logic [1:0] {
        OP_ALT  = 2'b00,
        OP_HADD = 2'b01,
        OP_HSUB = 2'b10,
        OP_PASS = 2'b11
    } hsa_op_e;

endpackage

// File: rtl/hsa_fp_add.sv
// One lane adder: round-to-nearest-even, flush-to-zero, canonical quiet NaN.
module hsa_fp_add #(
    parameter int EW = 8,
    parameter int MW = 23
) (
    input  logic [EW+MW:0] x_i,
    input  logic [EW+MW:0] y_i,
    input  logic           neg_i,
    output logic [EW+MW:0] z_o
);
    localparam int FW  = EW + MW + 1;
    localparam int W   = MW + 5;            // carry, hidden, fraction, guard, round, sticky
    localparam int XW  = EW + 2;            // signed working exponent
    localparam int LZW = $clog2(W) + 1;
    localparam logic [EW-1:0] EMAX = '1;
    localparam logic [FW-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

    typedef struct packed {
        logic          s;
        logic [EW-1:0] e;
        logic [MW-1:0] m;
    } fp_t;

    fp_t            xa, yb, big, sml, z;
    logic           x_nan, y_nan, x_inf, y_inf, x_zero, y_zero;
    logic [EW-1:0]  dexp;
    logic [W-1:0]   fbig, fsml, shf, sum, norm;
    logic           stk, found, rnd, ovf, unf;
    logic [LZW-1:0] lz;
    logic [XW-1:0]  e;
    logic [MW+1:0]  mr;

    always_comb begin
        xa   = x_i;
        yb   = y_i;
        yb.s = y_i[FW-1] ^ neg_i;

        x_nan  = (xa.e == EMAX) && (xa.m != '0);
        y_nan  = (yb.e == EMAX) && (yb.m != '0);
        x_inf  = (xa.e == EMAX) && (xa.m == '0);
        y_inf  = (yb.e == EMAX) && (yb.m == '0);
        x_zero = (xa.e == '0);
        y_zero = (yb.e == '0);

        // order by magnitude so the subtraction never goes negative
        if ({xa.e, xa.m} >= {yb.e, yb.m}) begin
            big = xa;
            sml = yb;
        end else begin
            big = yb;
            sml = xa;
        end

        dexp = big.e - sml.e;
        fbig = {2'b01, big.m, 3'b000};
        fsml = {2'b01, sml.m, 3'b000};
        if (32'(dexp) >= W) begin
            shf = '0;
            stk = 1'b1;
        end else begin
            shf = fsml >> dexp;
            stk = |(fsml & ~({W{1'b1}} << dexp));
        end
        shf[0] = shf[0] | stk;

        sum = (big.s == sml.s) ? fbig + shf : fbig - shf;

        lz    = '0;
        found = 1'b0;
        for (int i = W - 2; i >= 0; i--) begin
            if (!found) begin
                if (sum[i]) found = 1'b1;
                else        lz    = lz + LZW'(1);
            end
        end

        e = XW'(big.e);
        if (sum[W-1]) begin
            norm = {1'b0, sum[W-1:2], sum[1] | sum[0]};
            e    = e + XW'(1);
        end else begin
            norm = sum << lz;
            e    = e - XW'(lz);
        end

        rnd = norm[2] & (norm[1] | norm[0] | norm[3]);
        mr  = {1'b0, norm[W-2:3]} + (MW+2)'(rnd);
        if (mr[MW+1]) e = e + XW'(1);

        ovf = !e[XW-1] && (e[XW-2:0] >= {1'b0, EMAX});
        unf = e[XW-1] || (e == '0);

        z.s = big.s;
        if (ovf) begin
            z.e = EMAX;
            z.m = '0;
        end else if (unf) begin
            z.e = '0;
            z.m = '0;
        end else begin
            z.e = e[EW-1:0];
            z.m = mr[MW-1:0];
        end
        if (sum == '0) z = '0;

        // special operands override the arithmetic path, NaN last
        if (x_zero && y_zero) z = {xa.s & yb.s, {(FW-1){1'b0}}};
        else if (x_zero)      z = yb;
        else if (y_zero)      z = xa;
        if (x_inf || y_inf)   z = {(x_inf ? xa.s : yb.s), EMAX, {MW{1'b0}}};
        if (x_inf && y_inf && (xa.s != yb.s)) z = QNAN;
        if (x_nan || y_nan)   z = QNAN;

        z_o = z;
    end

endmodule

// File: rtl/hsa_steer.sv
// Routes operand elements to lane adders for the selected pattern.
module hsa_steer
    import hsa_pkg::*;
#(
    parameter int LW = 32,
    parameter int NL = 4
) (
    input  logic [NL-1:0][LW-1:0] a_i,
    input  logic [NL-1:0][LW-1:0] b_i,
    input  hsa_op_e               op_i,
    output logic [NL-1:0][LW-1:0] x_o,
    output logic [NL-1:0][LW-1:0] y_o,
    output logic [NL-1:0]         neg_o
);
    localparam int HALF = NL / 2;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        localparam int PI = 2 * (i % HALF);
        logic [LW-1:0] hx, hy, lx, ly;
        logic          ln;

        if (i < HALF) begin : g_from_a
            assign hx = a_i[PI];
            assign hy = a_i[PI+1];
        end else begin : g_from_b
            assign hx = b_i[PI];
            assign hy = b_i[PI+1];
        end

        always_comb begin
            case (op_i)
                OP_ALT: begin
                    lx = a_i[i];
                    ly = b_i[i];
                    ln = ((i % 2) == 0);
                end
                OP_HADD: begin
                    lx = hx;
                    ly = hy;
                    ln = 1'b0;
                end
                OP_HSUB: begin
                    lx = hx;
                    ly = hy;
                    ln = 1'b1;
                end
                default: begin
                    lx = a_i[i];
                    ly = '0;
                    ln = 1'b0;
                end
            endcase
        end

        assign x_o[i]   = lx;
        assign y_o[i]   = ly;
        assign neg_o[i] = ln;
    end

endmodule

// File: rtl/hsa_unit.sv
module hsa_unit
    import hsa_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_op,
    input  logic             in_dbl,
    input  logic [VEC_W-1:0] in_a,
    input  logic [VEC_W-1:0] in_b,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_data
);
    localparam int NS = VEC_W / SP_W;
    localparam int ND = VEC_W / DP_W;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] data;
    } st_t;

    st_t     st_d, st_q;
    hsa_op_e op;

    logic [NS-1:0][SP_W-1:0] s_x, s_y, s_z;
    logic [NS-1:0]           s_neg;
    logic [ND-1:0][DP_W-1:0] d_x, d_y, d_z;
    logic [ND-1:0]           d_neg;
    logic [VEC_W-1:0]        res;

    assign op = hsa_op_e'(in_op);

    hsa_steer #(.LW(SP_W), .NL(NS)) u_steer_sp (
        .a_i(in_a), .b_i(in_b), .op_i(op),
        .x_o(s_x), .y_o(s_y), .neg_o(s_neg)
    );

    hsa_steer #(.LW(DP_W), .NL(ND)) u_steer_dp (
        .a_i(in_a), .b_i(in_b), .op_i(op),
        .x_o(d_x), .y_o(d_y), .neg_o(d_neg)
    );

    for (genvar i = 0; i < NS; i++) begin : g_sp
        hsa_fp_add #(.EW(SP_EW), .MW(SP_MW)) u_add (
            .x_i(s_x[i]), .y_i(s_y[i]), .neg_i(s_neg[i]), .z_o(s_z[i])
        );
    end

    for (genvar i = 0; i < ND; i++) begin : g_dp
        hsa_fp_add #(.EW(DP_EW), .MW(DP_MW)) u_add (
            .x_i(d_x[i]), .y_i(d_y[i]), .neg_i(d_neg[i]), .z_o(d_z[i])
        );
    end

    always_comb begin
        if (op == OP_PASS) res = in_a;
        else if (in_dbl)   res = d_z;
        else               res = s_z;
    end

    assign in_ready = !st_q.vld || out_ready;

    always_comb begin
        st_d = st_q;
        if (in_ready) st_d.vld = in_valid;
        if (in_valid && in_ready) st_d.data = res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;

    // R10: an accepted operation is visible on the next edge
    p_accept_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R11: a stalled result neither drops nor changes
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R5: opcode 11 returns operand A bit-for-bit
    p_pass_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == 2'b11) |=> (out_data == $past(in_a)));

    // R9: a NaN in A lane 0 under single horizontal add gives the quiet NaN
    p_nan_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_dbl && in_op == 2'b01 &&
         in_a[30:23] == 8'hFF && in_a[22:0] != '0)
        |=> (out_data[31:0] == 32'h7FC0_0000));

endmodule

// File: tb/sim_hsa_unit.sv
module sim_hsa_unit;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid, in_ready, in_dbl, out_valid, out_ready;
    logic [1:0]   in_op;
    logic [127:0] in_a, in_b, out_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsa_unit #(.VEC_W(128)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_dbl(in_dbl), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic real sf2r(logic [31:0] f);
        logic [63:0] d;
        if (f[30:23] == 8'h00) return 0.0;
        d = {f[31], 11'(32'(f[30:23]) - 127 + 1023), f[22:0], 29'b0};
        return $bitstoreal(d);
    endfunction

    function automatic logic [31:0] r2sf(real r);
        logic [63:0] d;
        d = $realtobits(r);
        if (r == 0.0) return {d[63], 31'b0};
        return {d[63], 8'(32'(d[62:52]) - 1023 + 127), d[51:29]};
    endfunction

    // expected vector from the lane patterns (operands chosen exactly representable)
    function automatic logic [127:0] model(logic [1:0] op, logic dbl,
                                          logic [127:0] a, logic [127:0] b);
        logic [127:0] m;
        real ra[4], rb[4], r;
        m = '0;
        if (op == 2'b11) return a;
        if (!dbl) begin
            for (int i = 0; i < 4; i++) begin
                ra[i] = sf2r(a[32*i +: 32]);
                rb[i] = sf2r(b[32*i +: 32]);
            end
            for (int i = 0; i < 4; i++) begin
                if (op == 2'b00)      r = (i % 2 == 0) ? ra[i] - rb[i] : ra[i] + rb[i];
                else if (op == 2'b01) r = (i < 2) ? ra[2*i] + ra[2*i+1] : rb[2*i-4] + rb[2*i-3];
                else                  r = (i < 2) ? ra[2*i] - ra[2*i+1] : rb[2*i-4] - rb[2*i-3];
                m[32*i +: 32] = r2sf(r);
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                ra[i] = $bitstoreal(a[64*i +: 64]);
                rb[i] = $bitstoreal(b[64*i +: 64]);
            end
            if (op == 2'b00) begin
                m[63:0]   = $realtobits(ra[0] - rb[0]);
                m[127:64] = $realtobits(ra[1] + rb[1]);
            end else if (op == 2'b01) begin
                m[63:0]   = $realtobits(ra[0] + ra[1]);
                m[127:64] = $realtobits(rb[0] + rb[1]);
            end else begin
                m[63:0]   = $realtobits(ra[0] - ra[1]);
                m[127:64] = $realtobits(rb[0] - rb[1]);
            end
        end
        return m;
    endfunction

    task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one operation, sampled on the negedge after the accepting edge
    task automatic run_op(logic [1:0] op, logic dbl, logic [127:0] a, logic [127:0] b,
                          output logic [127:0] got, output logic vld);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_dbl = dbl; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        got = out_data;
        vld = out_valid;
    endtask

    task automatic lane0_sp(string req, logic [1:0] op, logic [31:0] a0, logic [31:0] a1,
                            logic [31:0] exp0);
        logic [127:0] got;
        logic vld;
        run_op(op, 1'b0, {64'b0, a1, a0}, '0, got, vld);
        check(req, "single lane0 corner", got, {96'b0, exp0});
    endtask

    task automatic lane0_dp(string req, logic [63:0] a0, logic [63:0] a1, logic [63:0] exp0);
        logic [127:0] got;
        logic vld;
        run_op(2'b01, 1'b1, {a1, a0}, '0, got, vld);
        check(req, "double lane0 corner", got, {64'b0, exp0});
    endtask

    function automatic real rnd_val();
        return real'(int'($urandom_range(512)) - 256) / 8.0;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] a, b, got, e1, e2;
        logic vld;
        string rq;
        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_dbl = 1'b0;
        in_a = '0; in_b = '0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", "reset out_valid", 128'(out_valid), 128'(0));
        check("R11", "reset in_ready", 128'(in_ready), 128'(1));
        rst_n = 1'b1;

        // sweep: R1 R2 R3 single, R4 double, R5 pass, R10 latency
        for (int op = 0; op < 4; op++) begin
            for (int dbl = 0; dbl < 2; dbl++) begin
                for (int k = 0; k < 40; k++) begin
                    for (int i = 0; i < 4; i++) begin
                        a[32*i +: 32] = r2sf(rnd_val());
                        b[32*i +: 32] = r2sf(rnd_val());
                    end
                    if (dbl == 1) begin
                        for (int i = 0; i < 2; i++) begin
                            a[64*i +: 64] = $realtobits(rnd_val());
                            b[64*i +: 64] = $realtobits(rnd_val());
                        end
                    end
                    run_op(2'(op), 1'(dbl), a, b, got, vld);
                    if (op == 3)      rq = "R5";
                    else if (dbl == 1) rq = "R4";
                    else if (op == 0) rq = "R1";
                    else if (op == 1) rq = "R2";
                    else              rq = "R3";
                    check(rq, "sweep result", got, model(2'(op), 1'(dbl), a, b));
                    check("R10", "valid one cycle after accept", 128'(vld), 128'(1));
                end
            end
        end

        // R5: special encodings pass unchanged
        a = {32'h7F80_0001, 32'h0000_0001, 32'hFFC0_0000, 32'h8000_0000};
        run_op(2'b11, 1'b0, a, '1, got, vld);
        check("R5", "pass NaN/subnormal single", got, a);
        run_op(2'b11, 1'b1, a, '1, got, vld);
        check("R5", "pass in double mode", got, a);

        // R6 rounding, nearest-even
        lane0_sp("R6", 2'b01, 32'h3F80_0000, 32'h3380_0000, 32'h3F80_0000);
        lane0_sp("R6", 2'b01, 32'h3F80_0001, 32'h3380_0000, 32'h3F80_0002);
        lane0_sp("R6", 2'b01, 32'h3F80_0000, 32'h33C0_0000, 32'h3F80_0001);
        lane0_dp("R6", 64'h3FF0_0000_0000_0000, 64'h3CA0_0000_0000_0000, 64'h3FF0_0000_0000_0000);
        lane0_dp("R6", 64'h3FF0_0000_0000_0001, 64'h3CA0_0000_0000_0000, 64'h3FF0_0000_0000_0002);

        // R7 flush to zero
        lane0_sp("R7", 2'b01, 32'h3F80_0000, 32'h0000_0001, 32'h3F80_0000);
        lane0_sp("R7", 2'b01, 32'h0040_0000, 32'h0000_0000, 32'h0000_0000);
        lane0_sp("R7", 2'b10, 32'h00C0_0000, 32'h0080_0000, 32'h0000_0000);
        lane0_sp("R7", 2'b10, 32'h8080_0000, 32'h80C0_0000, 32'h0000_0000);

        // R8 overflow to signed infinity
        lane0_sp("R8", 2'b01, 32'h7F7F_FFFF, 32'h7F7F_FFFF, 32'h7F80_0000);
        lane0_sp("R8", 2'b01, 32'hFF7F_FFFF, 32'hFF7F_FFFF, 32'hFF80_0000);
        lane0_dp("R8", 64'h7FEF_FFFF_FFFF_FFFF, 64'h7FEF_FFFF_FFFF_FFFF, 64'h7FF0_0000_0000_0000);

        // R9 NaN and invalid infinity sums
        lane0_sp("R9", 2'b01, 32'h7FC0_0000, 32'h3F80_0000, 32'h7FC0_0000);
        lane0_sp("R9", 2'b01, 32'h3F80_0000, 32'hFF80_0001, 32'h7FC0_0000);
        lane0_sp("R9", 2'b01, 32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000);
        lane0_sp("R9", 2'b10, 32'h7F80_0000, 32'h7F80_0000, 32'h7FC0_0000);
        lane0_sp("R9", 2'b01, 32'h7F80_0000, 32'h7F80_0000, 32'h7F80_0000);
        lane0_dp("R9", 64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, 64'h7FF8_0000_0000_0000);

        // R10 back-to-back acceptance
        a = {r2sf(1.0), r2sf(2.0), r2sf(3.0), r2sf(4.0)};
        b = {r2sf(0.5), r2sf(0.25), r2sf(-6.0), r2sf(8.0)};
        e1 = model(2'b01, 1'b0, a, b);
        e2 = model(2'b00, 1'b0, b, a);
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'b01; in_dbl = 1'b0; in_a = a; in_b = b;
        @(negedge clk);
        check("R10", "first of back-to-back", out_data, e1);
        in_op = 2'b00; in_a = b; in_b = a;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10", "second of back-to-back", out_data, e2);
        check("R10", "valid after second", 128'(out_valid), 128'(1));

        // R11 backpressure
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_op = 2'b10; in_dbl = 1'b0; in_a = a; in_b = b;
        e1 = model(2'b10, 1'b0, a, b);
        @(negedge clk);
        check("R11", "stalled result value", out_data, e1);
        check("R11", "ready low while stalled", 128'(in_ready), 128'(0));
        in_op = 2'b00; in_a = b; in_b = a;
        @(negedge clk);
        check("R11", "result held", out_data, e1);
        check("R11", "valid held", 128'(out_valid), 128'(1));
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11", "queued operation after release", out_data, e2);
        @(negedge clk);
        check("R10", "valid drops when idle", 128'(out_valid), 128'(0));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule